// File: doc/BRIEF.md
# Zero-overhead loop PC controller

This block owns the program counter of an in-order core that retires one instruction bundle at a time. For every retired bundle it works out the address of the next bundle. It supports a hardware repeat block, which is a loop described by a start address, an end address, a 32-bit trip counter and a loop-active flag in the status word. Because the loop-back is handled here, the loop body needs no branch instruction of its own. The block also watches for an instruction-address breakpoint and, on a hit, enters the debug trap. It accepts external interrupts, and it can hold one of them waiting while interrupts are masked.

The retire stage presents each bundle on a valid/ready input. A bundle carries the branch outcome and any status-word or counter write made by the instruction. A bundle is taken when `in_valid` and `in_ready` are both high. Every bundle taken, and every interrupt delivered, places a new program counter on the valid/ready output `nx_*`. That output holds its value until the fetch side raises `nx_ready`. While the output is still waiting, `in_ready` stays low, so back-pressure from fetch flows straight back to retire.

The status word, the debug and backup copies, and the trip counter are plain outputs. The block does not switch stack banks itself. It raises `stack_swap` for one cycle whenever the stack-select bit of the status word changes.

Top module: `zol_pc_ctrl`

## Requirements
- R1: Reset state: the program counter, status word, trip counter, debug copies and backup copies are all zero. No interrupt is pending and `nx_valid` is low.
- R2: Handshake: `in_ready` is high only when the output slot is empty or being taken this cycle, and no interrupt is being delivered this cycle. While `nx_valid` is high and `nx_ready` is low, `nx_pc` and `nx_valid` hold.
- R3: Counter decrement: when a bundle is taken at the loop end address, the counter drops by one if it was nonzero or the loop-active bit was set. This decision uses the values held before the bundle. A counter of zero with the loop-active bit set therefore wraps to 0xFFFFFFFF.
- R4: Instruction counter writes: a counter write made by the bundle replaces the value left by the decrement. The loop-back decision still uses whether the counter was nonzero before the bundle.
- R5: Loop-active clear: after the bundle, the loop-active bit is cleared if it is set, the bundle was at the end address and the resulting counter is zero.
- R6: Next-address priority: a valid branch target comes first. The loop start address comes next, and applies when the post-bundle loop-active bit is set, the pre-bundle counter was nonzero and the bundle was at the end address. Otherwise the next address is the bundle address plus 8.
- R7: Breakpoint entry: if the bundle address equals `brk_addr` and the post-bundle debug-enable bit is set, the following happens. `dbg_pc` takes the address chosen by R6. `dbg_psw` takes the status word with bit EA set. The status word becomes SM kept, DS set and all other bits clear. The next address becomes 0xFFFFF128.
- R8: Interrupt delivery: with IE set, a request (new or pending) causes the following. `bak_psw` and `bak_pc` take the current status word and program counter. The status word becomes zero and the next address becomes 0xFFFFF138.
- R9: Pending latch: a request that is not delivered sets a one-deep pending flag. Further requests are dropped while the flag is set. The flag is retried every cycle and clears when the interrupt is delivered.
- R10: Stack swap: `stack_swap` is high for exactly the cycle after an update in which SM changed.
- R11: Status word layout and writes: bit 0 is SM, bit 1 EA, bit 2 DB, bit 3 DS, bit 4 IE and bit 5 RP (loop-active). A bundle's status write replaces exactly the bits set in `psw_wmask` with the matching bits of `psw_wdata`. This write is applied before R5 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_start | input | 32 | Repeat block start address |
| loop_end | input | 32 | Address of the last bundle in the repeat block |
| brk_addr | input | 32 | Instruction breakpoint address |
| in_valid | input | 1 | Retired bundle present |
| in_ready | output | 1 | Bundle accepted this cycle when high together with in_valid |
| br_valid | input | 1 | Bundle produced a branch |
| br_target | input | 32 | Branch target address |
| psw_wmask | input | 32 | Status bits written by the bundle |
| psw_wdata | input | 32 | Values for the written status bits |
| cnt_we | input | 1 | Bundle writes the trip counter |
| cnt_wdata | input | 32 | New trip counter value |
| irq | input | 1 | External interrupt request |
| nx_valid | output | 1 | Next program counter available |
| nx_ready | input | 1 | Fetch takes the next program counter |
| nx_pc | output | 32 | Next program counter |
| psw_o | output | 32 | Current status word |
| count_o | output | 32 | Current trip counter |
| dbg_pc | output | 32 | Saved address at debug entry |
| dbg_psw | output | 32 | Saved status word at debug entry |
| bak_pc | output | 32 | Saved address at interrupt entry |
| bak_psw | output | 32 | Saved status word at interrupt entry |
| irq_pend | output | 1 | An interrupt is pending |
| stack_swap | output | 1 | Stack bank change request pulse |

## Verification
The loop logic is run through three full passes of a four-bundle body. This separates the loop-back with a count left from the pass where the loop-active bit clears, and both from the fall-through exit. Two end-address cases then separate the pre-bundle sample from the post-bundle counter: a zero counter with the loop-active bit set, once plain (which wraps) and once with an instruction counter write. A branch at the loop end shows that the branch wins over the loop-back. Breakpoint bundles with the debug-enable bit set and clear show the trap entry against a plain step. Masked repeated requests, an unmask and an immediate request separate the pending, discard and delivery paths, and a stalled fetch side exercises back-pressure.

// File: rtl/zol_pkg.sv
package zol_pkg;
  localparam int PSW_W = 32;
  // status word bit positions
  localparam int B_SM = 0;
  localparam int B_EA = 1;
  localparam int B_DB = 2;
  localparam int B_DS = 3;
  localparam int B_IE = 4;
  localparam int B_RP = 5;
endpackage

// File: rtl/zol_loop_unit.sv
module zol_loop_unit
  import zol_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int STEP = 8
) (
  input  logic [AW-1:0]    cia,
  input  logic [AW-1:0]    start_addr,
  input  logic [AW-1:0]    end_addr,
  input  logic             br_valid,
  input  logic [AW-1:0]    br_target,
  input  logic [CW-1:0]    cnt_cur,
  input  logic             cnt_we,
  input  logic [CW-1:0]    cnt_wdata,
  input  logic [PSW_W-1:0] psw_cur,
  input  logic [PSW_W-1:0] psw_wmask,
  input  logic [PSW_W-1:0] psw_wdata,
  output logic [CW-1:0]    cnt_new,
  output logic [PSW_W-1:0] psw_new,
  output logic [AW-1:0]    pc_new
);
  logic             at_end;
  logic             was_nz;
  logic             dec_en;
  logic             rp_after;
  logic             loop_back;
  logic [CW-1:0]    cnt_dec;
  logic [PSW_W-1:0] psw_exec;

  always_comb begin
    at_end    = (cia == end_addr);
    was_nz    = (cnt_cur != '0);
    dec_en    = at_end && (was_nz || psw_cur[B_RP]);
    cnt_dec   = dec_en ? (cnt_cur - CW'(1)) : cnt_cur;
    cnt_new   = cnt_we ? cnt_wdata : cnt_dec;
    psw_exec  = (psw_cur & ~psw_wmask) | (psw_wdata & psw_wmask);
    rp_after  = psw_exec[B_RP];
    psw_new   = psw_exec;
    if (rp_after && at_end && (cnt_new == '0)) psw_new[B_RP] = 1'b0;
    loop_back = rp_after && was_nz && at_end;
    if (br_valid)       pc_new = br_target;
    else if (loop_back) pc_new = start_addr;
    else                pc_new = cia + AW'(STEP);
  end
endmodule

// File: rtl/zol_dbg_entry.sv
module zol_dbg_entry
  import zol_pkg::*;
#(
  parameter int              AW      = 32,
  parameter logic [AW-1:0]   DBG_VEC = AW'(32'hFFFF_F128)
) (
  input  logic [AW-1:0]    cia,
  input  logic [AW-1:0]    brk_addr,
  input  logic [AW-1:0]    pc_in,
  input  logic [PSW_W-1:0] psw_in,
  output logic             hit,
  output logic [AW-1:0]    pc_out,
  output logic [PSW_W-1:0] psw_out,
  output logic [AW-1:0]    dpc_out,
  output logic [PSW_W-1:0] dpsw_out
);
  logic [PSW_W-1:0] marked;

  always_comb begin
    hit          = (cia == brk_addr) && psw_in[B_DB];
    marked       = psw_in;
    marked[B_EA] = 1'b1;
    dpsw_out     = marked;
    dpc_out      = pc_in;
    if (hit) begin
      psw_out       = '0;
      psw_out[B_SM] = psw_in[B_SM];
      psw_out[B_DS] = 1'b1;
      pc_out        = DBG_VEC;
    end else begin
      psw_out = psw_in;
      pc_out  = pc_in;
    end
  end
endmodule

// File: rtl/zol_irq_gate.sv
module zol_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic ie,
  input  logic slot_free,
  output logic take,
  output logic pend
);
  logic pend_q;

  assign take = (irq || pend_q) && ie && slot_free;
  assign pend = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    pend_q <= 1'b0;
    else if (take) pend_q <= 1'b0;
    else if (irq)  pend_q <= 1'b1;
  end

  assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take) |=> pend_q);
  assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !take) |=> pend_q);
  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !irq) |=> !pend_q);
endmodule

// File: rtl/zol_pc_ctrl.sv
module zol_pc_ctrl
  import zol_pkg::*;
#(
  parameter int            AW      = 32,
  parameter int            CW      = 32,
  parameter int            STEP    = 8,
  parameter logic [AW-1:0] DBG_VEC = AW'(32'hFFFF_F128),
  parameter logic [AW-1:0] INT_VEC = AW'(32'hFFFF_F138)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    loop_start,
  input  logic [AW-1:0]    loop_end,
  input  logic [AW-1:0]    brk_addr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             br_valid,
  input  logic [AW-1:0]    br_target,
  input  logic [PSW_W-1:0] psw_wmask,
  input  logic [PSW_W-1:0] psw_wdata,
  input  logic             cnt_we,
  input  logic [CW-1:0]    cnt_wdata,
  input  logic             irq,
  output logic             nx_valid,
  input  logic             nx_ready,
  output logic [AW-1:0]    nx_pc,
  output logic [PSW_W-1:0] psw_o,
  output logic [CW-1:0]    count_o,
  output logic [AW-1:0]    dbg_pc,
  output logic [PSW_W-1:0] dbg_psw,
  output logic [AW-1:0]    bak_pc,
  output logic [PSW_W-1:0] bak_psw,
  output logic             irq_pend,
  output logic             stack_swap
);
  logic [AW-1:0]    pc_q, dpc_q, bpc_q;
  logic [PSW_W-1:0] psw_q, dpsw_q, bpsw_q;
  logic [CW-1:0]    cnt_q;
  logic             nxv_q, swap_q;

  logic             slot_free, take, accept, advance;
  logic [CW-1:0]    cnt_l;
  logic [PSW_W-1:0] psw_l, psw_t, dpsw_t, psw_d;
  logic [AW-1:0]    pc_l, pc_t, dpc_t;
  logic             hit;

  assign slot_free = !nxv_q || nx_ready;
  assign in_ready  = slot_free && !take;
  assign accept    = in_valid && in_ready;
  assign advance   = accept || take;

  zol_loop_unit #(.AW(AW), .CW(CW), .STEP(STEP)) u_loop (
    .cia(pc_q), .start_addr(loop_start), .end_addr(loop_end),
    .br_valid(br_valid), .br_target(br_target),
    .cnt_cur(cnt_q), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .psw_cur(psw_q), .psw_wmask(psw_wmask), .psw_wdata(psw_wdata),
    .cnt_new(cnt_l), .psw_new(psw_l), .pc_new(pc_l)
  );

  zol_dbg_entry #(.AW(AW), .DBG_VEC(DBG_VEC)) u_dbg (
    .cia(pc_q), .brk_addr(brk_addr), .pc_in(pc_l), .psw_in(psw_l),
    .hit(hit), .pc_out(pc_t), .psw_out(psw_t),
    .dpc_out(dpc_t), .dpsw_out(dpsw_t)
  );

  zol_irq_gate u_irq (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ie(psw_q[B_IE]),
    .slot_free(slot_free), .take(take), .pend(irq_pend)
  );

  always_comb begin
    if (take)        psw_d = '0;
    else if (accept) psw_d = psw_t;
    else             psw_d = psw_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      psw_q  <= '0;
      cnt_q  <= '0;
      dpc_q  <= '0;
      dpsw_q <= '0;
      bpc_q  <= '0;
      bpsw_q <= '0;
      nxv_q  <= 1'b0;
      swap_q <= 1'b0;
    end else begin
      swap_q <= psw_d[B_SM] != psw_q[B_SM];
      psw_q  <= psw_d;
      if (take) begin
        bpc_q  <= pc_q;
        bpsw_q <= psw_q;
        pc_q   <= INT_VEC;
      end else if (accept) begin
        cnt_q <= cnt_l;
        pc_q  <= pc_t;
        if (hit) begin
          dpc_q  <= dpc_t;
          dpsw_q <= dpsw_t;
        end
      end
      if (advance)       nxv_q <= 1'b1;
      else if (nx_ready) nxv_q <= 1'b0;
    end
  end

  assign nx_valid   = nxv_q;
  assign nx_pc      = pc_q;
  assign psw_o      = psw_q;
  assign count_o    = cnt_q;
  assign dbg_pc     = dpc_q;
  assign dbg_psw    = dpsw_q;
  assign bak_pc     = bpc_q;
  assign bak_psw    = bpsw_q;
  assign stack_swap = swap_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nx_valid && !nx_ready) |=> (nx_valid && $stable(nx_pc)));
  assert_no_accept_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nx_valid && !nx_ready) |-> !in_ready);
  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (pc_q == loop_end) && (cnt_q != '0) && !cnt_we)
      |=> (count_o == $past(cnt_q) - CW'(1)));
  assert_dbg_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (nx_pc == DBG_VEC && psw_o[B_DS] && nx_valid));
  assert_int_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (nx_pc == INT_VEC && psw_o == '0 && nx_valid));
  assert_swap_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stack_swap == (psw_o[B_SM] != $past(psw_o[B_SM]))));
endmodule

// File: tb/sim_zol_pc_ctrl.sv
`timescale 1ns/1ps
module sim_zol_pc_ctrl;
  import zol_pkg::*;

  localparam logic [31:0] LS = 32'h100;
  localparam logic [31:0] LE = 32'h118;
  localparam logic [31:0] BK = 32'h300;
  localparam logic [31:0] DV = 32'hFFFF_F128;
  localparam logic [31:0] IV = 32'hFFFF_F138;
  localparam logic [31:0] M_SM = 32'h01, M_EA = 32'h02, M_DB = 32'h04;
  localparam logic [31:0] M_DS = 32'h08, M_IE = 32'h10, M_RP = 32'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        in_valid = 0, br_valid = 0, cnt_we = 0, irq = 0, nx_ready = 1;
  logic [31:0] br_target = 0, psw_wmask = 0, psw_wdata = 0, cnt_wdata = 0;
  logic        in_ready, nx_valid, irq_pend, stack_swap;
  logic [31:0] nx_pc, psw_o, count_o, dbg_pc, dbg_psw, bak_pc, bak_psw;

  zol_pc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .loop_start(LS), .loop_end(LE), .brk_addr(BK),
    .in_valid(in_valid), .in_ready(in_ready), .br_valid(br_valid),
    .br_target(br_target), .psw_wmask(psw_wmask), .psw_wdata(psw_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .irq(irq),
    .nx_valid(nx_valid), .nx_ready(nx_ready), .nx_pc(nx_pc),
    .psw_o(psw_o), .count_o(count_o), .dbg_pc(dbg_pc), .dbg_psw(dbg_psw),
    .bak_pc(bak_pc), .bak_psw(bak_psw), .irq_pend(irq_pend),
    .stack_swap(stack_swap)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] psw;
    logic [31:0] cnt;
    logic        swap;
  } exp_t;

  exp_t  q[$];
  string qtag[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 0;

  logic [31:0] m_pc = 0, m_psw = 0, m_cnt = 0;
  logic [31:0] m_dpc = 0, m_dpsw = 0, m_bpc = 0, m_bpsw = 0;
  bit          m_pend = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(string tag, logic [31:0] pc, logic [31:0] psw,
                      logic [31:0] cnt, logic swap);
    exp_t e;
    e.pc = pc; e.psw = psw; e.cnt = cnt; e.swap = swap;
    q.push_back(e);
    qtag.push_back(tag);
  endtask

  // model of interrupt entry (R8)
  task automatic model_deliver(string tag);
    logic old_sm;
    old_sm = m_psw[B_SM];
    m_bpsw = m_psw;
    m_bpc  = m_pc;
    m_psw  = '0;
    m_pc   = IV;
    m_pend = 0;
    push(tag, m_pc, m_psw, m_cnt, old_sm);
  endtask

  // driver: predicts the result from the requirements, then hands the bundle over
  task automatic step(string tag, logic bv, logic [31:0] bt, logic [31:0] wm,
                      logic [31:0] wd, logic cwe, logic [31:0] cwd);
    logic [31:0] cia, np, p;
    logic        snz, rpw, old_sm;
    cia    = m_pc;
    old_sm = m_psw[B_SM];
    snz    = (m_cnt != 0);
    if (cia == LE && (m_cnt != 0 || m_psw[B_RP])) m_cnt = m_cnt - 1;
    if (cwe) m_cnt = cwd;
    p   = (m_psw & ~wm) | (wd & wm);
    rpw = p[B_RP];
    if (rpw && cia == LE && m_cnt == 0) p[B_RP] = 1'b0;
    if (bv)                        np = bt;
    else if (rpw && snz && cia == LE) np = LS;
    else                           np = cia + 32'd8;
    if (cia == BK && p[B_DB]) begin
      m_dpc  = np;
      p      = p | M_EA;
      m_dpsw = p;
      p      = (p & M_SM) | M_DS;
      np     = DV;
    end
    m_psw = p;
    m_pc  = np;
    push(tag, np, p, m_cnt, old_sm != p[B_SM]);
    if (m_pend && m_psw[B_IE]) model_deliver("R8/R9 pending delivery");
    @(negedge clk);
    br_valid = bv; br_target = bt; psw_wmask = wm; psw_wdata = wd;
    cnt_we = cwe; cnt_wdata = cwd; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 0; br_valid = 0; cnt_we = 0; psw_wmask = 0; psw_wdata = 0;
  endtask

  task automatic irq_pulse();
    if (m_psw[B_IE]) model_deliver("R8 immediate delivery");
    else if (!m_pend) m_pend = 1;
    @(negedge clk);
    irq = 1'b1;
    @(posedge clk);
    #1;
    irq = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pops one expected item per output handshake
  always @(negedge clk) begin
    exp_t  e;
    string t;
    if (rst_n && nx_valid && nx_ready) begin
      if (q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R2: actual unexpected pc %h expected no output", nx_pc);
      end else begin
        e = q.pop_front();
        t = qtag.pop_front();
        check({t, " next pc"}, nx_pc, e.pc);
        check({t, " status word"}, psw_o, e.psw);
        check({t, " counter"}, count_o, e.cnt);
        check({t, " R10 stack_swap"}, {31'd0, stack_swap}, {31'd0, e.swap});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit bp_done;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 nx_valid", {31'd0, nx_valid}, 32'd0);
    check("R1 pc", nx_pc, 32'd0);
    check("R1 psw", psw_o, 32'd0);
    check("R1 count", count_o, 32'd0);
    check("R1 pending", {31'd0, irq_pend}, 32'd0);
    check("R1 debug copies", dbg_pc | dbg_psw, 32'd0);
    check("R1 backup copies", bak_pc | bak_psw, 32'd0);
    rst_n = 1'b1;

    // R6 branch into the loop, R11 masked write sets RP, counter = 2
    step("R6/R11 enter loop", 1, LS, M_RP | M_SM, M_RP, 1, 32'd2);
    // R3 R5 R6: three passes of a four-bundle body
    for (int i = 0; i < 12; i++) step("R3/R5/R6 loop body", 0, 0, 0, 0, 0, 0);
    settle();
    check("R6 exit address", nx_pc, 32'h120);
    check("R5 RP cleared", psw_o & M_RP, 32'd0);

    // R4: zero counter with RP, instruction writes counter at end address
    step("R4 setup", 1, LE, M_RP, M_RP, 1, 32'd0);
    step("R4 write at end", 0, 0, 0, 0, 1, 32'd3);
    settle();
    check("R4 falls through", nx_pc, 32'h120);
    check("R4 counter written", count_o, 32'd3);
    check("R5 RP kept with nonzero counter", psw_o & M_RP, M_RP);

    // R3: zero counter with RP wraps
    step("R3 setup", 1, LE, 0, 0, 1, 32'd0);
    step("R3 wrap", 0, 0, 0, 0, 0, 0);
    settle();
    check("R3 wrapped counter", count_o, 32'hFFFF_FFFF);

    // R6: branch beats loop-back
    step("R6 setup", 1, LE, M_RP, M_RP, 1, 32'd2);
    step("R6 branch at end", 1, 32'h400, 0, 0, 0, 0);
    settle();
    check("R6 branch wins", nx_pc, 32'h400);

    // R7 breakpoint with DB set, SM changes on the way in (R10)
    step("R7/R10 go to breakpoint", 1, BK, M_RP | M_DB | M_SM, M_DB | M_SM, 0, 0);
    step("R7 breakpoint hit", 0, 0, 0, 0, 0, 0);
    settle();
    check("R7 dbg_pc", dbg_pc, m_dpc);
    check("R7 dbg_psw", dbg_psw, M_DB | M_SM | M_EA);
    check("R7 vector", nx_pc, DV);
    // R7 negative: DB cleared, no trap
    step("R7 DB clear setup", 1, BK, M_DB, 0, 0, 0);
    step("R7 no hit", 0, 0, 0, 0, 0, 0);
    settle();
    check("R7 plain step", nx_pc, BK + 32'd8);

    // R9 masked requests
    irq_pulse();
    settle();
    check("R9 pending set", {31'd0, irq_pend}, 32'd1);
    check("R9 no delivery while masked", nx_pc, BK + 32'd8);
    irq_pulse();
    settle();
    check("R9 still one pending", {31'd0, irq_pend}, 32'd1);
    step("R8/R9 unmask", 0, 0, M_IE, M_IE, 0, 0);
    settle();
    check("R9 pending cleared", {31'd0, irq_pend}, 32'd0);
    check("R8 bak_pc", bak_pc, m_bpc);
    check("R8 bak_psw", bak_psw, m_bpsw);
    step("R8 second unmask", 0, 0, M_IE, M_IE, 0, 0);
    irq_pulse();
    settle();
    check("R8 immediate bak_pc", bak_pc, IV + 32'd8);
    check("R8 immediate vector", nx_pc, IV);

    // R2 back-pressure
    @(posedge clk);
    #1;
    nx_ready = 1'b0;
    bp_done = 0;
    fork
      begin
        step("R2 first", 0, 0, 0, 0, 0, 0);
        step("R2 second", 0, 0, 0, 0, 0, 0);
        bp_done = 1;
      end
    join_none
    repeat (5) @(negedge clk);
    check("R2 in_ready low", {31'd0, in_ready}, 32'd0);
    check("R2 held pc", nx_pc, IV + 32'd8);
    @(posedge clk);
    #1;
    nx_ready = 1'b1;
    wait (bp_done);
    settle();
    check("R2 all results delivered", q.size(), 32'd0);

    finished = 1;
    summary();
    $finish;
  end
endmodule